// File: doc/BRIEF.md
# Sequential Reservation-Blocking Crossbar Scheduler

This block computes one conflict-free crossbar match per schedule for an N-port input-queued cell switch. The caller presents an N×N matrix of per-destination queue lengths and pulses `start`. The scheduler then visits the inputs one at a time, lowest index first, for exactly N steps. In each step the visited input reserves one output. Once an output is reserved, it is closed to every input visited after it. Because of this, the finished match never has two inputs on one output or two outputs on one input, and no second pass is needed.

Each step has two phases, and each phase takes one clock cycle. In the first phase the active input looks only at outputs that are still open and have a non-empty queue. It picks the one with the most cells. When lengths are equal, a per-input rotating pointer decides. In the second phase the chosen output is recorded in the transfer matrix and marked blocked. The transfer matrix and the blocked vector stay valid after `done` until the next accepted start.

Top module: `rbs_sched`

## Requirements
- R1: After reset, `done` is 0, every bit of `xfer` is 0, every bit of `blocked` is 0, and all rotating pointers are at output 0.
- R2: A start sampled at a clock edge while idle makes `done` high for exactly one cycle. That cycle begins at the 2N-th rising edge after the sampling edge, and `done` is low in every other cycle of the schedule.
- R3: Bit `i*N+j` of `xfer` means input i sends to output j. Each row and each column of `xfer` has at most one bit set.
- R4: An input reserves the open output whose queue length is largest. Queue length for input i, output j is `qlen[(i*N+j)*QW +: QW]`, unsigned.
- R5: Among equal largest lengths, an input takes the first candidate at or after its rotating pointer, scanning upward with wrap. After a reservation the pointer moves to one past the reserved output, with wrap. The pointer does not move when no reservation is made, and it keeps its value from one schedule to the next.
- R6: A queue of length zero is never reserved. An input with no open, non-empty queue makes no reservation, and its step leaves `xfer` and `blocked` unchanged.
- R7: Bit j of `blocked` is 1 exactly when some input holds a reservation on output j.
- R8: An accepted start clears `xfer` and `blocked` at the same edge.
- R9: A start that arrives while a schedule is running, or in the `done` cycle, has no effect. The running schedule's result and timing are unchanged.
- R10: Inputs are visited in ascending index order. When several inputs want the same output, the lowest-indexed input with a non-empty queue to it gets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a schedule (accepted only when idle) |
| qlen | input | N*N*QW | Queue lengths; entry (i,j) at `(i*N+j)*QW` |
| xfer | output | N*N | Transfer matrix; bit i*N+j means input i to output j |
| blocked | output | N | Per-output reserved flag |
| done | output | 1 | One-cycle pulse when the match is complete |

## Verification
The assertions assume that `qlen` holds still from the accepted start until `done`. The check that a reserved queue was non-empty compares against the length seen one cycle earlier, so that check depends on `qlen` being stable. The bench changes `qlen` only between schedules, while the block is idle. The stimulus mixes random lengths from a small range, which gives many ties and many empty queues. Directed cases add an all-empty matrix, an all-equal matrix, a single contested output, maximum-value entries, and a start injected mid-schedule.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PICK  = 2'd1,
        PH_BLOCK = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/rbs_row_sel.sv
module rbs_row_sel #(
    parameter int N  = 4,
    parameter int QW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*N*QW-1:0] qlen,
    input  logic [IW-1:0]     sel,
    output logic [N*QW-1:0]   row
);
    always_comb begin
        row = qlen[int'(sel)*N*QW +: N*QW];
    end
endmodule

// File: rtl/rbs_pick.sv
module rbs_pick #(
    parameter int N  = 4,
    parameter int QW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*QW-1:0] row,
    input  logic [N-1:0]    blocked,
    input  logic [IW-1:0]   ptr,
    output logic            vld,
    output logic [IW-1:0]   idx
);
    logic [QW-1:0] best;

    always_comb begin
        vld  = 1'b0;
        idx  = '0;
        best = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            logic [QW-1:0] len;
            j   = (int'(ptr) + k) % N;
            len = row[j*QW +: QW];
            if (!blocked[j] && (len != '0) && (!vld || (len > best))) begin
                vld  = 1'b1;
                idx  = IW'(j);
                best = len;
            end
        end
    end
endmodule

// File: rtl/rbs_sched.sv
module rbs_sched
    import rbs_pkg::*;
#(
    parameter int N  = 4,
    parameter int QW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*N*QW-1:0] qlen,
    output logic [N*N-1:0]    xfer,
    output logic [N-1:0]      blocked,
    output logic              done
);
    typedef struct packed {
        phase_e                ph;
        logic [IW-1:0]         step;
        logic                  pick_vld;
        logic [IW-1:0]         pick_idx;
        logic [N*N-1:0]        xfer;
        logic [N-1:0]          blocked;
        logic [N-1:0][IW-1:0]  ptr;
    } st_t;

    st_t r_d, r_q;

    logic [N*QW-1:0] act_row;
    logic            pk_vld;
    logic [IW-1:0]   pk_idx;
    logic            busy;

    rbs_row_sel #(.N(N), .QW(QW)) u_row (
        .qlen (qlen),
        .sel  (r_q.step),
        .row  (act_row)
    );

    rbs_pick #(.N(N), .QW(QW)) u_pick (
        .row     (act_row),
        .blocked (r_q.blocked),
        .ptr     (r_q.ptr[r_q.step]),
        .vld     (pk_vld),
        .idx     (pk_idx)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.xfer     = '0;
                    r_d.blocked  = '0;
                    r_d.step     = '0;
                    r_d.pick_vld = 1'b0;
                    r_d.ph       = PH_PICK;
                end
            end
            PH_PICK: begin
                r_d.pick_vld = pk_vld;
                r_d.pick_idx = pk_idx;
                r_d.ph       = PH_BLOCK;
            end
            PH_BLOCK: begin
                if (r_q.pick_vld) begin
                    r_d.xfer[int'(r_q.step)*N + int'(r_q.pick_idx)] = 1'b1;
                    r_d.blocked[r_q.pick_idx] = 1'b1;
                    r_d.ptr[r_q.step] = (int'(r_q.pick_idx) == N-1) ? '0
                                        : r_q.pick_idx + IW'(1);
                end
                if (int'(r_q.step) == N-1) begin
                    r_d.ph = PH_DONE;
                end else begin
                    r_d.step = r_q.step + IW'(1);
                    r_d.ph   = PH_PICK;
                end
            end
            PH_DONE: begin
                r_d.ph = PH_IDLE;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, step: '0, pick_vld: 1'b0, pick_idx: '0,
                     xfer: '0, blocked: '0, ptr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.ph != PH_IDLE);
    assign xfer    = r_q.xfer;
    assign blocked = r_q.blocked;
    assign done    = (r_q.ph == PH_DONE);
endmodule

// File: rtl/rbs_sched_chk.sv
module rbs_sched_chk #(
    parameter int N  = 4,
    parameter int QW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [N*N*QW-1:0] qlen,
    input logic [N*N-1:0]    xfer,
    input logic [N-1:0]      blocked,
    input logic              done
);
    logic [N-1:0][N-1:0] col;
    logic [N-1:0]        col_or;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col[j][i] = xfer[i*N+j];
            end
            col_or[j] = |col[j];
        end
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (xfer == '0 && blocked == '0));

    p_blk_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blocked == col_or);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(xfer) && $stable(blocked)));

    for (genvar g = 0; g < N; g++) begin : g_one
        p_row_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(xfer[g*N +: N]));
        p_col_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[g]));
    end

    for (genvar k = 0; k < N*N; k++) begin : g_nz
        p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(xfer[k]) |-> ($past(qlen[k*QW +: QW]) != '0));
    end
endmodule

bind rbs_sched rbs_sched_chk #(.N(N), .QW(QW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .qlen    (qlen),
    .xfer    (xfer),
    .blocked (blocked),
    .done    (done)
);

// File: tb/rbs_sched_test.sv
`timescale 1ns/1ps
module rbs_sched_test;
    localparam int N  = 4;
    localparam int QW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*N*QW-1:0] qlen = '0;
    logic [N*N-1:0]    xfer;
    logic [N-1:0]      blocked;
    logic              done;

    int checks = 0;
    int fails  = 0;
    int q   [N][N];
    int ptr [N];

    always #2 clk = ~clk;

    rbs_sched #(.N(N), .QW(QW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .qlen(qlen),
        .xfer(xfer), .blocked(blocked), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N*N-1:0] model();
        logic [N*N-1:0] m = '0;
        logic [N-1:0]   blk = '0;
        for (int i = 0; i < N; i++) begin
            int best = 0;
            int sel  = -1;
            for (int k = 0; k < N; k++) begin
                int j = (ptr[i] + k) % N;
                if (!blk[j] && q[i][j] > best) begin
                    best = q[i][j];
                    sel  = j;
                end
            end
            if (sel >= 0) begin
                m[i*N+sel] = 1'b1;
                blk[sel]   = 1'b1;
                ptr[i]     = (sel + 1) % N;
            end
        end
        return m;
    endfunction

    function automatic logic [N-1:0] cols(input logic [N*N-1:0] m);
        logic [N-1:0] c = '0;
        for (int i = 0; i < N; i++) c = c | m[i*N +: N];
        return c;
    endfunction

    task automatic pack();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                qlen[(i*N+j)*QW +: QW] = QW'(q[i][j]);
    endtask

    task automatic run(input string tag, input bit inject);
        logic [N*N-1:0] exp;
        bit timing_ok = 1'b1;
        pack();
        exp = model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R8: cleared right after the accepted start
        chk(xfer == '0 && blocked == '0, "R8", {tag, " clear"}, {xfer, blocked}, 0);
        for (int c = 1; c <= 2*N+1; c++) begin
            @(negedge clk);
            start = (inject && (c == 2 || c == 2*N)) ? 1'b1 : 1'b0;
            if (done != (c == 2*N)) timing_ok = 1'b0;
        end
        start = 1'b0;
        chk(timing_ok, "R2", {tag, " done timing"}, 0, 0);
        chk(xfer == exp, "R4 R5 R6 R10", {tag, " xfer"}, xfer, exp);
        chk(blocked == cols(exp), "R7", {tag, " blocked"}, blocked, cols(exp));
        repeat (2) @(negedge clk);
        // R9: nothing restarted after an injected start
        chk(xfer == exp && !done, "R9", {tag, " idle hold"}, xfer, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) ptr[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && xfer == '0 && blocked == '0, "R1", "reset",
            {done, xfer, blocked}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: all empty, no reservation, pointers stay
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) q[i][j] = 0;
        run("R6 empty", 1'b0);
        chk(xfer == '0, "R6", "empty no reservation", xfer, 0);

        // R5: all equal, round-robin rotation over several runs
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) q[i][j] = 2;
        for (int r = 0; r < 3; r++) run("R5 equal", 1'b0);

        // R10: one contested output, later inputs longer
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
            q[i][j] = (j == 2) ? i + 1 : 0;
        run("R10 contest", 1'b0);
        chk(xfer[2] == 1'b1, "R10", "input0 wins output2", xfer, 64'h4);

        // R4: maximum value beats others
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
            q[i][j] = (i == j) ? 15 : 14;
        run("R4 max", 1'b0);

        // R9: start injected mid-run and in done cycle
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
            q[i][j] = int'($urandom_range(0, 3));
        run("R9 inject", 1'b1);

        // random mix
        for (int r = 0; r < 150; r++) begin
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
                q[i][j] = ($urandom_range(0, 3) == 0) ? 0
                          : int'($urandom_range(1, (r % 2) ? 3 : 15));
            run("R3 random", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule